// File: doc/BRIEF.md
# PIPE PHY Command Sequencer

This block sits between a link training state machine and a PIPE-style SuperSpeed PHY. It turns two kinds of request into PHY signalling. The first is "detect a receiver". The second is "move to power state Px". For receiver detection it raises the detect/loopback request line and waits for the PHY's PhyStatus handshake, then reports whether a receiver was found. For a power change it drives the PowerDown lines and waits for PhyStatus to confirm the change. A change that leaves P0 first spends a programmable delay and then a short settle period before the new value is presented.

The sequencer takes one command at a time through a valid/ready handshake. It finishes each command with either a one-cycle done pulse or a one-cycle timeout pulse. A timeout occurs when PhyStatus does not come back within a programmable number of cycles. Its 3-bit state code is always visible on a debug output.

Top module: `pipe_cmd_seq`

## Requirements
- R1: After reset, dbg_state is 0 (idle), power_down is 2 (P2), tx_det_rx is 0, req_ready is 1, and done, det_present and timeout are 0.
- R2: req_ready is 1 only while dbg_state is 0. A request offered while busy is ignored: the command in progress goes on unchanged and no extra command runs.
- R3: An accepted request with req_kind=0 (detect) gives dbg_state 1 for exactly one cycle, then dbg_state 2. tx_det_rx is 1 in both of these states and 0 otherwise.
- R4: In dbg_state 2, PhyStatus=1 returns the block to dbg_state 0 in the next cycle. In that same cycle done is 1 for one cycle. det_present is 1 with it exactly when rx_status was 3'b011 in the cycle PhyStatus was sampled.
- R5: An accepted request with req_kind=1 whose target req_pwr differs from P0 (encoding 0), issued while power_down is P0, passes through dbg_state 3 for DLY_CYC cycles, then dbg_state 4 for SETTLE_CYC cycles, then dbg_state 5. power_down keeps its old value until dbg_state 5 is entered and holds the target from then on.
- R6: Any other power request (current state not P0, or target P0) skips dbg_state 3. It spends SETTLE_CYC cycles in dbg_state 4 and then enters dbg_state 5 with power_down set to the target.
- R7: In dbg_state 5, PhyStatus=1 returns the block to idle in the next cycle with a one-cycle done pulse, and det_present stays 0.
- R8: If PhyStatus stays 0 for TMO_CYC cycles in dbg_state 2 or 5, the block returns to idle with a one-cycle timeout pulse and no done. After a power request times out, power_down keeps the target value.
- R9: PhyStatus is ignored outside dbg_state 2 and 5. It neither shortens the delay or settle states nor produces done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY parallel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command offered |
| req_kind | input | 1 | 0 = receiver detect, 1 = power change |
| req_pwr | input | 2 | Target power state for a power change (0=P0 .. 3=P3) |
| req_ready | output | 1 | Sequencer idle, command accepted when req_valid is 1 |
| phy_status | input | 1 | PHY completion handshake |
| rx_status | input | 3 | PHY receive status, 3'b011 means receiver present |
| tx_det_rx | output | 1 | Receiver detection request to the PHY |
| power_down | output | 2 | Power state request to the PHY |
| done | output | 1 | One-cycle completion pulse |
| det_present | output | 1 | Receiver found, valid with done |
| timeout | output | 1 | One-cycle pulse when PhyStatus did not arrive in time |
| dbg_state | output | 3 | Current command state code |

## Verification
The detect path is driven with PhyStatus arriving at once, after a few cycles, and one cycle before the limit. This separates correct wait handling from an off-by-one timeout. rx_status values of present, absent and another code show that only 3'b011 counts as found. Power requests are issued from P0 and from P2, P1 and P3, and toward P0 and away from it, which shows when the delay stage is used and when it is skipped. Timeouts on both wait states, busy requests, and PhyStatus glitches during the delay state show that stray inputs change nothing.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_DET      = 3'd1,
    ST_DET_WAIT = 3'd2,
    ST_PWR_DLY  = 3'd3,
    ST_PWR_SET  = 3'd4,
    ST_PWR_WAIT = 3'd5
  } pcs_state_e;

  localparam logic [1:0] PWR_P0       = 2'd0;
  localparam logic [1:0] PWR_RST      = 2'd2;
  localparam logic [2:0] RXST_PRESENT = 3'b011;
endpackage

// File: rtl/pcs_timer.sv
module pcs_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          zero
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (dec && (cnt_q != '0));
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // R8: counter never wraps below zero
  p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && zero) |=> zero);
endmodule

// File: rtl/pcs_fsm.sv
module pcs_fsm
  import pcs_pkg::*;
#(
  parameter int DLY_CYC    = 4,
  parameter int SETTLE_CYC = 2,
  parameter int TMO_CYC    = 64,
  parameter int CW         = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_kind,
  input  logic [1:0]    req_pwr,
  input  logic          phy_status,
  input  logic [2:0]    rx_status,
  input  logic          tmr_zero,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          tmr_dec,
  output logic          req_ready,
  output logic          tx_det_rx,
  output logic [1:0]    power_down,
  output logic          done,
  output logic          det_present,
  output logic          timeout,
  output logic [2:0]    state_o
);
  localparam logic [CW-1:0] DLY_LD = CW'(DLY_CYC - 1);
  localparam logic [CW-1:0] SET_LD = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] TMO_LD = CW'(TMO_CYC - 1);

  pcs_state_e state_q, state_d;
  logic [1:0] pend_q, pwr_q;
  logic       pend_en, pwr_en;
  logic       done_d, det_d, tmo_d;
  logic       done_q, det_q, tmo_q;
  logic       in_wait;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    tmr_dec  = 1'b0;
    pend_en  = 1'b0;
    pwr_en   = 1'b0;
    done_d   = 1'b0;
    det_d    = 1'b0;
    tmo_d    = 1'b0;
    in_wait  = (state_q == ST_DET_WAIT) || (state_q == ST_PWR_WAIT);
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (!req_kind) begin
            state_d = ST_DET;
          end else begin
            pend_en  = 1'b1;
            tmr_load = 1'b1;
            if ((pwr_q == PWR_P0) && (req_pwr != PWR_P0)) begin
              state_d = ST_PWR_DLY;
              tmr_val = DLY_LD;
            end else begin
              state_d = ST_PWR_SET;
              tmr_val = SET_LD;
            end
          end
        end
      end
      ST_DET: begin
        state_d  = ST_DET_WAIT;
        tmr_load = 1'b1;
        tmr_val  = TMO_LD;
      end
      ST_PWR_DLY: begin
        if (tmr_zero) begin
          state_d  = ST_PWR_SET;
          tmr_load = 1'b1;
          tmr_val  = SET_LD;
        end else begin
          tmr_dec = 1'b1;
        end
      end
      ST_PWR_SET: begin
        if (tmr_zero) begin
          state_d  = ST_PWR_WAIT;
          tmr_load = 1'b1;
          tmr_val  = TMO_LD;
          pwr_en   = 1'b1;
        end else begin
          tmr_dec = 1'b1;
        end
      end
      ST_DET_WAIT, ST_PWR_WAIT: begin
        if (phy_status) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          det_d   = (state_q == ST_DET_WAIT) && (rx_status == RXST_PRESENT);
        end else if (tmr_zero) begin
          state_d = ST_IDLE;
          tmo_d   = 1'b1;
        end else begin
          tmr_dec = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      det_q   <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      det_q   <= det_d;
      tmo_q   <= tmo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= PWR_RST;
    else if (pend_en) pend_q <= req_pwr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pwr_q <= PWR_RST;
    else if (pwr_en) pwr_q <= pend_q;
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign tx_det_rx   = (state_q == ST_DET) || (state_q == ST_DET_WAIT);
  assign power_down  = pwr_q;
  assign done        = done_q;
  assign det_present = det_q;
  assign timeout     = tmo_q;
  assign state_o     = state_q;

  // R2: an offered request in idle is always taken
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid) |=> !req_ready);
  // R3: detect request lasts one cycle and leads into the wait
  p_det_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DET) |=> (state_q == ST_DET_WAIT) && tx_det_rx);
  // R4: completion follows a sampled handshake and lands in idle
  p_done_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(phy_status) && req_ready));
  // R5: the power request changes only when the wait state is entered
  p_pwr_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(power_down) |-> (state_q == ST_PWR_WAIT));
  // R7: a receiver result never appears without completion
  p_det_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    det_present |-> done);
  // R8: timeout excludes done and follows a silent handshake line
  p_tmo_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (!done && !$past(phy_status)));
  // R9: handshake cannot cut the delay state short
  p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_PWR_DLY) && !tmr_zero) |=> (state_q == ST_PWR_DLY));
  // R8: the two completion pulses never coincide
  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({done, timeout}) <= 1);
endmodule

// File: rtl/pipe_cmd_seq.sv
module pipe_cmd_seq #(
  parameter int DLY_CYC    = 4,
  parameter int SETTLE_CYC = 2,
  parameter int TMO_CYC    = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_kind,
  input  logic [1:0] req_pwr,
  output logic       req_ready,
  input  logic       phy_status,
  input  logic [2:0] rx_status,
  output logic       tx_det_rx,
  output logic [1:0] power_down,
  output logic       done,
  output logic       det_present,
  output logic       timeout,
  output logic [2:0] dbg_state
);
  localparam int MAX_A = (DLY_CYC > SETTLE_CYC) ? DLY_CYC : SETTLE_CYC;
  localparam int MAX_C = (MAX_A > TMO_CYC) ? MAX_A : TMO_CYC;
  localparam int CW    = $clog2(MAX_C + 1);

  initial begin
    p_param_r5: assert (DLY_CYC >= 1 && SETTLE_CYC >= 1 && TMO_CYC >= 1);
  end

  logic          tmr_load, tmr_dec, tmr_zero;
  logic [CW-1:0] tmr_val;

  pcs_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .dec      (tmr_dec),
    .zero     (tmr_zero)
  );

  pcs_fsm #(
    .DLY_CYC    (DLY_CYC),
    .SETTLE_CYC (SETTLE_CYC),
    .TMO_CYC    (TMO_CYC),
    .CW         (CW)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_kind    (req_kind),
    .req_pwr     (req_pwr),
    .phy_status  (phy_status),
    .rx_status   (rx_status),
    .tmr_zero    (tmr_zero),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .tmr_dec     (tmr_dec),
    .req_ready   (req_ready),
    .tx_det_rx   (tx_det_rx),
    .power_down  (power_down),
    .done        (done),
    .det_present (det_present),
    .timeout     (timeout),
    .state_o     (dbg_state)
  );
endmodule

// File: tb/sim_pipe_cmd_seq.sv
module sim_pipe_cmd_seq;
  localparam int DLY = 4;
  localparam int SET = 2;
  localparam int TMO = 8;
  localparam int NV  = 10;

  // {kind, target power, wait cycles before PhyStatus, rx_status}
  localparam logic [10:0] VEC [NV] = '{
    {1'b0, 2'd0, 5'd0, 3'd3},
    {1'b0, 2'd0, 5'd3, 3'd0},
    {1'b1, 2'd0, 5'd1, 3'd0},
    {1'b1, 2'd1, 5'd2, 3'd0},
    {1'b1, 2'd0, 5'd0, 3'd0},
    {1'b1, 2'd3, 5'd8, 3'd0},
    {1'b0, 2'd0, 5'd2, 3'd3},
    {1'b1, 2'd0, 5'd5, 3'd0},
    {1'b0, 2'd0, 5'd9, 3'd3},
    {1'b0, 2'd0, 5'd7, 3'd4}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_kind, phy_status;
  logic [1:0] req_pwr;
  logic [2:0] rx_status;
  logic req_ready, tx_det_rx, done, det_present, timeout;
  logic [1:0] power_down;
  logic [2:0] dbg_state;

  int n_run = 0;
  int n_fail = 0;
  logic [1:0] cur_pwr;

  always #2 clk = ~clk;

  pipe_cmd_seq #(.DLY_CYC(DLY), .SETTLE_CYC(SET), .TMO_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_pwr(req_pwr), .req_ready(req_ready), .phy_status(phy_status),
    .rx_status(rx_status), .tx_det_rx(tx_det_rx), .power_down(power_down),
    .done(done), .det_present(det_present), .timeout(timeout),
    .dbg_state(dbg_state)
  );

  task automatic chk(input int act, input int exp, input string tag);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_reset();
    chk(dbg_state, 0, "R1 state");
    chk(power_down, 2, "R1 power_down");
    chk(tx_det_rx, 0, "R1 tx_det_rx");
    chk(req_ready, 1, "R1 ready");
    chk({done, det_present, timeout}, 0, "R1 pulses");
  endtask

  task automatic run_cmd(input logic kind, input logic [1:0] pwr,
                         input int wt, input logic [2:0] rx);
    int wst;
    logic leave;
    @(negedge clk);
    chk(req_ready, 1, "R2 ready in idle");
    req_valid = 1'b1; req_kind = kind; req_pwr = pwr;
    @(negedge clk);
    req_valid = 1'b0;
    if (!kind) begin
      chk(dbg_state, 1, "R3 detect request state");
      chk(tx_det_rx, 1, "R3 tx_det_rx in request");
      @(negedge clk);
      wst = 2;
    end else begin
      leave = (cur_pwr == 2'd0) && (pwr != 2'd0);
      if (leave) begin
        for (int i = 0; i < DLY; i++) begin
          chk(dbg_state, 3, "R5 delay state");
          chk(power_down, cur_pwr, "R5 power held in delay");
          @(negedge clk);
        end
      end
      for (int i = 0; i < SET; i++) begin
        chk(dbg_state, 4, leave ? "R5 settle state" : "R6 settle state");
        chk(power_down, cur_pwr, "R6 power held in settle");
        @(negedge clk);
      end
      chk(power_down, pwr, "R5 power applied on wait");
      wst = 5;
    end
    for (int i = 0; i < TMO && i < wt; i++) begin
      chk(dbg_state, wst, "R8 waiting");
      chk(tx_det_rx, !kind, "R3 tx_det_rx during wait");
      @(negedge clk);
    end
    if (wt < TMO) begin
      chk(dbg_state, wst, "R4 still waiting");
      phy_status = 1'b1; rx_status = rx;
      @(negedge clk);
      phy_status = 1'b0; rx_status = 3'd0;
      chk(dbg_state, 0, kind ? "R7 back to idle" : "R4 back to idle");
      chk(done, 1, kind ? "R7 done" : "R4 done");
      chk(timeout, 0, "R4 no timeout");
      chk(det_present, (!kind && rx == 3'b011), kind ? "R7 det zero" : "R4 det result");
      chk(tx_det_rx, 0, "R3 tx_det_rx released");
      @(negedge clk);
      chk(done, 0, "R4 done one cycle");
    end else begin
      chk(dbg_state, 0, "R8 idle after timeout");
      chk(timeout, 1, "R8 timeout pulse");
      chk(done, 0, "R8 no done");
      chk(det_present, 0, "R8 no det");
      @(negedge clk);
      chk(timeout, 0, "R8 timeout one cycle");
    end
    if (kind) begin
      chk(power_down, pwr, "R8 power kept");
      cur_pwr = pwr;
    end
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 1'b0; req_pwr = 2'd0;
    phy_status = 1'b0; rx_status = 3'd0;
    cur_pwr = 2'd2;
    repeat (3) @(negedge clk);
    chk_reset();
    rst_n = 1'b1;
    @(negedge clk);
    chk_reset();

    for (int v = 0; v < NV; v++)
      run_cmd(VEC[v][10], VEC[v][9:8], int'(VEC[v][7:3]), VEC[v][2:0]);

    // R2, R9: busy request and stray PhyStatus while delaying (now in P0)
    @(negedge clk);
    req_valid = 1'b1; req_kind = 1'b1; req_pwr = 2'd2;
    @(negedge clk);
    req_valid = 1'b1; req_kind = 1'b0; phy_status = 1'b1;
    chk(req_ready, 0, "R2 busy not ready");
    @(negedge clk);
    chk(dbg_state, 3, "R9 delay not cut");
    chk(done, 0, "R9 no done from stray handshake");
    @(negedge clk);
    req_valid = 1'b0; phy_status = 1'b0;
    chk(dbg_state, 3, "R2 busy request ignored");
    @(negedge clk);
    chk(dbg_state, 3, "R5 fourth delay cycle");
    @(negedge clk);
    chk(dbg_state, 4, "R5 settle after delay");
    @(negedge clk);
    @(negedge clk);
    chk(dbg_state, 5, "R5 wait entered");
    chk(power_down, 2, "R5 target applied");
    phy_status = 1'b1;
    @(negedge clk);
    phy_status = 1'b0;
    chk(done, 1, "R7 done after busy test");
    @(negedge clk);
    chk(dbg_state, 0, "R2 no extra command ran");
    chk(tx_det_rx, 0, "R2 no detect started");

    // R1: reset in the middle of a detect
    req_valid = 1'b1; req_kind = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_reset();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule